// File: doc/BRIEF.md
# Binary-Tap Programmable Serial Convolver

This block convolves a serial input word with a programmable pattern of single-bit taps. A parallel code word selects which taps are present: tap i is switched in when bit i of the code is 1, and it contributes the input delayed by i bit times. The input word arrives one bit per enabled clock, least significant bit first, starting on the clock that carries the word-start strobe. On each of those bit times the block outputs one small integer, the number of present taps that currently see a 1. The result is a mixed-binary digit stream: weighting digit k by 2^k gives the integer product of the code word and the input word. Turning the digits into plain binary is left to the logic downstream.

Each word occupies a frame of 2n-1 bit times: n data bits followed by n-1 padding positions. Inside the block the padding positions count as zero, and the tap history is cleared at each frame start, so adjacent products never overlap. A clock enable sets the bit rate. A new code word can be requested at any time. It takes effect only between frames, so every frame is convolved with one fixed tap pattern.

Top module: `bitap_conv`

## Requirements
- R1: After reset `smp_valid` is 0, `smp_out` is 0 and the tap pattern is all zero, so a word sent before any load gives only zero samples.
- R2: Let f[i] be bit i of the tap pattern, with bit 0 the LSB, and let g[j] be input bit j of the frame, with j=0 the bit sampled together with the strobe. Sample k (0 <= k <= 2n-2) is then the sum over i of f[i]*g[k-i], where g[m] is taken as 0 when m < 0 or m >= n.
- R3: A frame starts on an enabled clock where `word_start` is 1 and no frame is running. It then gives exactly 2n-1 single-clock `smp_valid` pulses. The first pulse is visible in the clock after the starting edge, and the rest follow one per later enabled clock.
- R4: The `din` value during padding positions n..2n-2 has no effect on any sample.
- R5: While `ce` is 0 the frame does not advance, `smp_valid` is 0 in the next cycle and `smp_out` holds its value.
- R6: A `word_start` pulse during a running frame is ignored. The frame keeps its samples and its length.
- R7: A `coef_load` pulse stores `coef_word` whether or not `ce` is high. If a frame is running, the current frame keeps its old taps and the new pattern applies from the next frame.
- R8: Frames can run back to back, with the next strobe on the enabled clock right after the last sample. No input bit of one frame reaches a sample of another.
- R9: `smp_out` is ceil(log2(n+1)) bits wide. All taps set with an all-ones input gives the peak value n at sample n-1.
- R10: Over one frame, the sum of sample k times 2^k equals the tap word times the input word taken as unsigned integers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Bit-time enable; one input bit per enabled clock |
| coef_load | input | 1 | Request to load a new tap pattern |
| coef_word | input | N_BITS | Tap pattern, bit i switches in the tap with delay i |
| din | input | 1 | Serial input bit, LSB first |
| word_start | input | 1 | Marks the first bit of an input word |
| smp_out | output | ceil(log2(N_BITS+1)) | Mixed-binary output digit |
| smp_valid | output | 1 | One pulse per produced digit |

## Verification
The bench builds the block with N_BITS=4. That gives 7-bit-time frames and 3-bit digits, so every tap delay and every padding position is reached within a few dozen clocks. At this size a full tap pattern with an all-ones input reaches the peak digit. The chosen words exercise every tap offset, and junk padding, stalls, stray strobes and mid-frame loads all fall inside a single frame. Each digit is predicted from the convolution formula, and the weighted digit sum of every frame is compared with the integer product.

// File: rtl/bitap_pkg.sv
package bitap_pkg;

    // Width of one output digit: at most n taps can be active together.
    function automatic int smp_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bitap_frame.sv
module bitap_frame #(
    parameter int N_BITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic word_start,
    output logic step_o,
    output logic start_o,
    output logic pad_o,
    output logic busy_o
);
    localparam int NS = 2 * N_BITS - 1;
    localparam int PW = $clog2(NS + 1);

    typedef struct packed {
        logic          active;
        logic [PW-1:0] pos;
    } frame_st_t;

    frame_st_t st_d, st_q;
    logic [PW-1:0] idx;

    always_comb begin
        st_d    = st_q;
        start_o = ce && !st_q.active && word_start;
        step_o  = ce && (st_q.active || word_start);
        idx     = start_o ? '0 : st_q.pos;
        pad_o   = (idx >= PW'(N_BITS));
        if (start_o) begin
            st_d.active = (NS > 1);
            st_d.pos    = PW'(1);
        end else if (ce && st_q.active) begin
            st_d.pos    = st_q.pos + PW'(1);
            st_d.active = (st_q.pos != PW'(NS - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.active;

    // R3: a running frame never counts past its last position
    p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.pos >= PW'(1) && st_q.pos <= PW'(NS - 1)));

    // R6: a stray strobe inside a frame neither restarts nor stalls it
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && ce && word_start && st_q.pos != PW'(NS - 1))
        |=> (st_q.pos == $past(st_q.pos) + PW'(1)));

endmodule

// File: rtl/bitap_taps.sv
module bitap_taps #(
    parameter int N_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coef_load,
    input  logic [N_BITS-1:0] coef_word,
    input  logic              frame_busy,
    output logic [N_BITS-1:0] taps_o
);
    typedef struct packed {
        logic [N_BITS-1:0] taps;
        logic [N_BITS-1:0] pend;
        logic              pend_v;
    } tap_st_t;

    tap_st_t st_d, st_q;
    logic    apply;

    always_comb begin
        st_d  = st_q;
        apply = !frame_busy && st_q.pend_v;
        if (apply) begin
            st_d.taps   = st_q.pend;
            st_d.pend_v = 1'b0;
        end
        if (coef_load) begin
            st_d.pend   = coef_word;
            st_d.pend_v = 1'b1;
        end
        taps_o = apply ? st_q.pend : st_q.taps;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: the stored pattern cannot move while a frame is in flight
    p_taps_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_busy |=> $stable(st_q.taps));

endmodule

// File: rtl/bitap_core.sv
module bitap_core #(
    parameter int N_BITS = 4,
    parameter int SW     = bitap_pkg::smp_width(N_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              start_i,
    input  logic              pad_i,
    input  logic              din,
    input  logic [N_BITS-1:0] taps_i,
    output logic [SW-1:0]     smp_out,
    output logic              smp_valid
);
    typedef struct packed {
        logic [N_BITS-1:0] hist;
        logic [SW-1:0]     out;
        logic              valid;
    } core_st_t;

    core_st_t          st_d, st_q;
    logic              bit_in;
    logic [N_BITS-1:0] h;
    logic [SW-1:0]     acc;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        bit_in     = din && !pad_i;
        h          = (start_i ? '0 : (st_q.hist << 1)) | {{(N_BITS-1){1'b0}}, bit_in};
        acc        = '0;
        for (int i = 0; i < N_BITS; i++) begin
            acc = acc + SW'(taps_i[i] & h[i]);
        end
        if (step_i) begin
            st_d.hist  = h;
            st_d.out   = acc;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_out   = st_q.out;
    assign smp_valid = st_q.valid;

    // R4: a padding position always enters the delay line as zero
    p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && pad_i) |=> !st_q.hist[0]);

    // R9: a digit never exceeds the number of taps
    p_digit_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.out <= SW'(N_BITS));

endmodule

// File: rtl/bitap_conv.sv
module bitap_conv #(
    parameter int N_BITS = 4,
    parameter int SW     = bitap_pkg::smp_width(N_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              coef_load,
    input  logic [N_BITS-1:0] coef_word,
    input  logic              din,
    input  logic              word_start,
    output logic [SW-1:0]     smp_out,
    output logic              smp_valid
);
    logic              step, start, pad, busy;
    logic [N_BITS-1:0] taps;

    bitap_frame #(.N_BITS(N_BITS)) frame_i (
        .clk(clk), .rst_n(rst_n), .ce(ce), .word_start(word_start),
        .step_o(step), .start_o(start), .pad_o(pad), .busy_o(busy)
    );

    bitap_taps #(.N_BITS(N_BITS)) taps_i (
        .clk(clk), .rst_n(rst_n), .coef_load(coef_load), .coef_word(coef_word),
        .frame_busy(busy), .taps_o(taps)
    );

    bitap_core #(.N_BITS(N_BITS), .SW(SW)) core_i (
        .clk(clk), .rst_n(rst_n), .step_i(step), .start_i(start), .pad_i(pad),
        .din(din), .taps_i(taps), .smp_out(smp_out), .smp_valid(smp_valid)
    );

    // R5: a disabled bit time produces no digit and leaves the output alone
    p_stall_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> (!smp_valid && $stable(smp_out)));

endmodule

// File: tb/bitap_conv_tb.sv
module bitap_conv_tb_top;
    localparam int N  = 4;
    localparam int NS = 2 * N - 1;
    localparam int SW = bitap_pkg::smp_width(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b0;
    logic          coef_load = 1'b0;
    logic [N-1:0]  coef_word = '0;
    logic          din = 1'b0;
    logic          word_start = 1'b0;
    logic [SW-1:0] smp_out;
    logic          smp_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int exp_q[$];
    int prod_q[$];
    int acc = 0;
    int widx = 0;
    int cur_max = 0;
    int word_max = 0;
    logic [N-1:0] model_taps = '0;

    always #5 clk = ~clk;

    bitap_conv #(.N_BITS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce(ce), .coef_load(coef_load),
        .coef_word(coef_word), .din(din), .word_start(word_start),
        .smp_out(smp_out), .smp_valid(smp_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: pops one expected digit per valid pulse
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3 unexpected digit", int'(smp_out), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(smp_out) == e, "R2 digit", int'(smp_out), e);
                acc += int'(smp_out) << widx;
                if (int'(smp_out) > cur_max) cur_max = int'(smp_out);
                widx++;
                if (widx == NS) begin
                    int p;
                    p = prod_q.pop_front();
                    chk(acc == p, "R10 weighted sum", acc, p);
                    word_max = cur_max;
                    acc = 0; widx = 0; cur_max = 0;
                end
            end
        end
    end

    task automatic load(input logic [N-1:0] v);
        coef_load = 1'b1; coef_word = v;
        @(negedge clk);
        coef_load = 1'b0;
        model_taps = v;
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) begin
            ce = 1'b1; word_start = 1'b0; din = 1'b0;
            @(negedge clk);
        end
    endtask

    // Driver: pushes expected digits, then shifts the frame in
    task automatic send_word(input logic [N-1:0] g, input bit junk, input int stall_at,
                             input int ws_at, input int load_at, input logic [N-1:0] load_val);
        for (int k = 0; k < NS; k++) begin
            int s;
            s = 0;
            for (int i = 0; i < N; i++)
                if (k - i >= 0 && k - i < N) s += int'(model_taps[i] & g[k - i]);
            exp_q.push_back(s);
        end
        prod_q.push_back(int'(model_taps) * int'(g));
        for (int k = 0; k < NS; k++) begin
            if (k == 1 && stall_at != 1)
                chk(smp_valid == 1'b1, "R3 first digit latency", int'(smp_valid), 1);
            if (k == stall_at) begin
                logic [SW-1:0] prev;
                prev = smp_out;
                ce = 1'b0; word_start = 1'b1; din = 1'b1;
                @(negedge clk);
                chk(smp_valid == 1'b0, "R5 stall valid", int'(smp_valid), 0);
                chk(smp_out == prev, "R5 stall hold", int'(smp_out), int'(prev));
            end
            ce = 1'b1;
            word_start = (k == 0) || (k == ws_at);
            din = (k < N) ? g[k] : junk;
            coef_load = (k == load_at);
            coef_word = load_val;
            @(negedge clk);
        end
        word_start = 1'b0; coef_load = 1'b0; din = 1'b0;
        if (load_at >= 0) model_taps = load_val;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL R3 watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(smp_valid == 1'b0, "R1 reset valid", int'(smp_valid), 0);
        chk(smp_out == '0, "R1 reset digit", int'(smp_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: default taps are zero
        send_word(4'b1011, 1'b0, -1, -1, -1, '0);
        idle(1);
        chk(word_max == 0, "R1 zero taps", word_max, 0);
        chk(smp_valid == 1'b0, "R3 exact digit count", int'(smp_valid), 0);
        // R2 / R10: 6 times 3
        load(4'b0110);
        idle(1);
        send_word(4'b0011, 1'b0, -1, -1, -1, '0);
        idle(2);
        // R4: padding driven with ones
        load(4'b1001);
        send_word(4'b1101, 1'b1, -1, -1, -1, '0);
        idle(1);
        // R5: stall inside the frame
        send_word(4'b0111, 1'b1, 3, -1, -1, '0);
        idle(1);
        // R6: stray strobe during the frame
        send_word(4'b1010, 1'b0, -1, 2, -1, '0);
        idle(1);
        chk(smp_valid == 1'b0, "R6 frame length kept", int'(smp_valid), 0);
        // R7 + R8: load mid-frame, then back-to-back frames
        send_word(4'b1110, 1'b1, -1, -1, 4, 4'b0101);
        send_word(4'b1011, 1'b1, -1, -1, -1, '0);
        send_word(4'b1111, 1'b0, -1, -1, -1, '0);
        idle(2);
        // R9: peak digit
        load(4'b1111);
        send_word(4'b1111, 1'b0, -1, -1, -1, '0);
        idle(2);
        chk(word_max == N, "R9 peak digit", word_max, N);
        chk(exp_q.size() == 0, "R3 missing digits", exp_q.size(), 0);
        finish_run();
    end

endmodule